// File: doc/BRIEF.md
# Dispatch Filter for the Issue Queue

This block sits between rename and the issue queue. Each cycle it receives a bundle of instruction slots and decides, one slot at a time in index order, where each one goes. An ordinary instruction gets an insert strobe into the issue queue. A memory reference, a non-speculative instruction or a no-op takes the bypass route. It is marked finished (issued, executed and allowed to commit) and only moves the queue tail, so commit can deal with it later.

The walk stops at the first empty slot. It also stops at an ordinary instruction that finds no free queue entry, and in that case it raises a halt request. The halt request tells the stage to block and tells rename to stall. Free space is tracked as a running count: it starts from the queue's free-entry count and drops by one with every insertion made in the same cycle. A slot-consumed count is reported, so the stage controller knows which slots still have to go to its skid buffer. Nothing is dispatched while the controller holds dispatch disabled (for example while the stage is squashing), nor while commit signals stall or squash.

All results are registered and appear one clock after the inputs.

Top module: `dispatch_filter`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every output is zero.
- R2: Slots are examined from index 0 upward. The first slot with its valid bit low ends the walk, and no later slot gets any strobe, even if it is valid.
- R3: A valid slot with none of the three class flags set, reached while at least one free entry remains, gets its insert strobe and no tail or finished mark.
- R4: A valid slot with any of the memory, non-speculative or no-op flags set gets its tail strobe and its finished mark (meaning issued, executed and can-commit), and never an insert strobe.
- R5: An ordinary slot reached when the running free count is zero raises the halt request. That slot and every later slot get no strobe.
- R6: A bypass-class slot is accepted even when the free count is zero, because it takes no queue entry.
- R7: The free count drops by one for each insertion within a bundle, so the number of insert strobes never exceeds the free count that was presented.
- R8: If dispatch enable is low, or commit stall or commit squash is high, then no strobe, mark or halt request is produced and the consumed count is zero.
- R9: The consumed-slot output equals the number of slots that received an insert or tail strobe. Those slots always form a contiguous run starting at slot 0.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Dispatch enable from the stage controller; low while squashing or blocked |
| cmt_stall_i | input | 1 | Stall indication from commit |
| cmt_squash_i | input | 1 | Squash indication from commit |
| vld_i | input | SLOTS | Per-slot valid bit |
| mem_i | input | SLOTS | Per-slot memory-reference flag |
| nspec_i | input | SLOTS | Per-slot non-speculative flag |
| nop_i | input | SLOTS | Per-slot no-op flag |
| free_i | input | FREE_W | Free issue-queue entries at the start of the cycle |
| ins_o | output | SLOTS | Per-slot insert strobe into the issue queue |
| tail_o | output | SLOTS | Per-slot tail-advance strobe for bypass-class slots |
| fin_o | output | SLOTS | Per-slot issued/executed/can-commit mark |
| halt_o | output | 1 | Block request and upstream stall when the queue fills |
| used_o | output | USED_W | Number of slots consumed this cycle |

## Verification
The hardest case to reach is a bundle that fills the queue partway through. To get there, the free count must be smaller than the number of ordinary slots, and bypass slots must sit after the point where the queue fills. Only then can the walk be seen to keep accepting bypass slots and then halt at a later ordinary slot. The bench reaches this by sweeping every mix of the five slot kinds (empty, ordinary, and each bypass flag) across four slots, against every free count from zero to the queue depth and every combination of the three gating inputs. The expected strobes are computed by an arithmetic walk in the bench.

// File: rtl/dispatch_filter_pkg.sv
package dispatch_filter_pkg;

    // Route chosen for one slot before the in-order walk is applied.
    typedef enum logic [1:0] {
        SC_EMPTY  = 2'd0,
        SC_QUEUE  = 2'd1,
        SC_BYPASS = 2'd2
    } slot_class_e;

endpackage

// File: rtl/dfq_slot_class.sv
module dfq_slot_class
    import dispatch_filter_pkg::*;
(
    input  logic        vld_i,
    input  logic        mem_i,
    input  logic        nspec_i,
    input  logic        nop_i,
    output slot_class_e cls_o
);

    always_comb begin
        if (!vld_i)
            cls_o = SC_EMPTY;
        else if (mem_i || nspec_i || nop_i)
            cls_o = SC_BYPASS;
        else
            cls_o = SC_QUEUE;
    end

endmodule

// File: rtl/dfq_walk.sv
module dfq_walk
    import dispatch_filter_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int FREE_W = 6,
    parameter int USED_W = 3
) (
    input  logic                     gate_i,
    input  slot_class_e [SLOTS-1:0]  cls_i,
    input  logic [FREE_W-1:0]        free_i,
    output logic [SLOTS-1:0]         ins_o,
    output logic [SLOTS-1:0]         tail_o,
    output logic                     halt_o,
    output logic [USED_W-1:0]        used_o
);

    logic              run;
    logic [FREE_W-1:0] room;
    logic [USED_W-1:0] cnt;

    always_comb begin
        ins_o  = '0;
        tail_o = '0;
        halt_o = 1'b0;
        run    = gate_i;
        room   = free_i;
        cnt    = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (run) begin
                unique case (cls_i[i])
                    SC_EMPTY: run = 1'b0;
                    SC_BYPASS: begin
                        tail_o[i] = 1'b1;
                        cnt       = cnt + USED_W'(1);
                    end
                    SC_QUEUE: begin
                        if (room == '0) begin
                            halt_o = 1'b1;
                            run    = 1'b0;
                        end else begin
                            ins_o[i] = 1'b1;
                            room     = room - FREE_W'(1);
                            cnt      = cnt + USED_W'(1);
                        end
                    end
                    default: run = 1'b0;
                endcase
            end
        end
        used_o = cnt;
    end

endmodule

// File: rtl/dfq_out_reg.sv
module dfq_out_reg #(
    parameter int SLOTS  = 4,
    parameter int USED_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  ins_d,
    input  logic [SLOTS-1:0]  tail_d,
    input  logic              halt_d,
    input  logic [USED_W-1:0] used_d,
    output logic [SLOTS-1:0]  ins_q,
    output logic [SLOTS-1:0]  tail_q,
    output logic              halt_q,
    output logic [USED_W-1:0] used_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_q  <= '0;
            tail_q <= '0;
            halt_q <= 1'b0;
            used_q <= '0;
        end else begin
            ins_q  <= ins_d;
            tail_q <= tail_d;
            halt_q <= halt_d;
            used_q <= used_d;
        end
    end

    // R4: a slot never takes both routes
    a_r4_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_q & tail_q) == '0);

    // R2: consumed slots form a run from slot 0
    a_r2_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (((ins_q | tail_q) + SLOTS'(1)) & (ins_q | tail_q)) == '0);

endmodule

// File: rtl/dispatch_filter.sv
module dispatch_filter
    import dispatch_filter_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int IQ_DEPTH = 32,
    localparam int FREE_W  = $clog2(IQ_DEPTH + 1),
    localparam int USED_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cmt_stall_i,
    input  logic              cmt_squash_i,
    input  logic [SLOTS-1:0]  vld_i,
    input  logic [SLOTS-1:0]  mem_i,
    input  logic [SLOTS-1:0]  nspec_i,
    input  logic [SLOTS-1:0]  nop_i,
    input  logic [FREE_W-1:0] free_i,
    output logic [SLOTS-1:0]  ins_o,
    output logic [SLOTS-1:0]  tail_o,
    output logic [SLOTS-1:0]  fin_o,
    output logic              halt_o,
    output logic [USED_W-1:0] used_o
);

    slot_class_e [SLOTS-1:0] cls;
    logic                    gate;
    logic [SLOTS-1:0]        ins_d;
    logic [SLOTS-1:0]        tail_d;
    logic                    halt_d;
    logic [USED_W-1:0]       used_d;

    assign gate = en_i && !cmt_stall_i && !cmt_squash_i;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        dfq_slot_class u_cls (
            .vld_i   (vld_i[s]),
            .mem_i   (mem_i[s]),
            .nspec_i (nspec_i[s]),
            .nop_i   (nop_i[s]),
            .cls_o   (cls[s])
        );
    end

    dfq_walk #(
        .SLOTS  (SLOTS),
        .FREE_W (FREE_W),
        .USED_W (USED_W)
    ) u_walk (
        .gate_i (gate),
        .cls_i  (cls),
        .free_i (free_i),
        .ins_o  (ins_d),
        .tail_o (tail_d),
        .halt_o (halt_d),
        .used_o (used_d)
    );

    dfq_out_reg #(
        .SLOTS  (SLOTS),
        .USED_W (USED_W)
    ) u_oreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .ins_d  (ins_d),
        .tail_d (tail_d),
        .halt_d (halt_d),
        .used_d (used_d),
        .ins_q  (ins_o),
        .tail_q (tail_o),
        .halt_q (halt_o),
        .used_q (used_o)
    );

    // Finished mark accompanies every bypass-route slot.
    assign fin_o = tail_o;

    // Becomes true once a full cycle of valid inputs has been sampled.
    logic chk_live;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_live <= 1'b0;
        else        chk_live <= 1'b1;
    end

    // R8: a gated cycle yields nothing
    a_r8_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_live && $past(!en_i || cmt_stall_i || cmt_squash_i))
        |-> (ins_o == '0 && tail_o == '0 && !halt_o && used_o == '0));

    // R7: never more insertions than free entries presented
    a_r7_ins_bound: assert property (@(posedge clk) disable iff (!rst_n)
        chk_live |-> ($countones(ins_o) <= int'($past(free_i))));

    // R9: consumed count matches the strobes
    a_r9_used_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ins_o | tail_o) == int'(used_o));

    // R5: a halt leaves at least one slot unconsumed
    a_r5_halt_partial: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (int'(used_o) < SLOTS));

endmodule

// File: tb/dispatch_filter_bench.sv
module dispatch_filter_bench;

    localparam int SLOTS  = 4;
    localparam int DEPTH  = 4;
    localparam int FREE_W = $clog2(DEPTH + 1);
    localparam int USED_W = $clog2(SLOTS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en_i = 1'b0;
    logic              cmt_stall_i = 1'b0;
    logic              cmt_squash_i = 1'b0;
    logic [SLOTS-1:0]  vld_i = '0;
    logic [SLOTS-1:0]  mem_i = '0;
    logic [SLOTS-1:0]  nspec_i = '0;
    logic [SLOTS-1:0]  nop_i = '0;
    logic [FREE_W-1:0] free_i = '0;
    logic [SLOTS-1:0]  ins_o, tail_o, fin_o;
    logic              halt_o;
    logic [USED_W-1:0] used_o;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    dispatch_filter #(.SLOTS(SLOTS), .IQ_DEPTH(DEPTH)) u_dispatch_filter (
        .clk, .rst_n, .en_i, .cmt_stall_i, .cmt_squash_i,
        .vld_i, .mem_i, .nspec_i, .nop_i, .free_i,
        .ins_o, .tail_o, .fin_o, .halt_o, .used_o
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slot code: 0 empty (nop flag set as noise), 1 ordinary, 2 mem, 3 non-spec, 4 nop
    task automatic drive(input int v, input int fr, input int g);
        for (int i = 0; i < SLOTS; i++) begin
            int c;
            c = (v / (5 ** i)) % 5;
            vld_i[i]   = (c != 0);
            mem_i[i]   = (c == 2);
            nspec_i[i] = (c == 3);
            nop_i[i]   = (c == 4) || (c == 0);
        end
        free_i       = FREE_W'(fr);
        en_i         = g[0];
        cmt_stall_i  = g[1];
        cmt_squash_i = g[2];
    endtask

    task automatic expect_walk(input int v, input int fr, input int g);
        logic [SLOTS-1:0] e_ins, e_tail;
        logic e_halt;
        int e_used, room;
        bit run;
        string rq;
        e_ins = '0; e_tail = '0; e_halt = 1'b0; e_used = 0; room = fr;
        run = (g == 1);
        for (int i = 0; i < SLOTS; i++) begin
            int c;
            c = (v / (5 ** i)) % 5;
            if (run) begin
                if (c == 0) run = 1'b0;
                else if (c >= 2) begin e_tail[i] = 1'b1; e_used++; end
                else if (room == 0) begin e_halt = 1'b1; run = 1'b0; end
                else begin e_ins[i] = 1'b1; room--; e_used++; end
            end
        end
        rq = (g == 1) ? "" : "R8 ";
        chk({rq, "R3 R7 R2"}, "ins", 32'(ins_o), 32'(e_ins));
        chk({rq, "R4 R6"}, "tail", 32'(tail_o), 32'(e_tail));
        chk({rq, "R4"}, "fin", 32'(fin_o), 32'(e_tail));
        chk({rq, "R5"}, "halt", 32'(halt_o), 32'(e_halt));
        chk({rq, "R9"}, "used", 32'(used_o), 32'(e_used));
    endtask

    task automatic step(input int v, input int fr, input int g);
        drive(v, fr, g);
        @(posedge clk); #1;
        expect_walk(v, fr, g);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with active inputs during reset
        drive(1, 4, 1);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "ins", 32'(ins_o), 0);
        chk("R1", "halt", 32'(halt_o), 0);
        chk("R1", "used", 32'(used_o), 0);
        drive(0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "tail", 32'(tail_o), 0);

        // R10: one-cycle latency
        drive(1, 4, 1);
        #1;
        chk("R10", "ins before edge", 32'(ins_o), 0);
        @(posedge clk); #1;
        chk("R10", "ins after edge", 32'(ins_o), 1);

        // R2: empty slot 1 hides ordinary slots 2 and 3 (codes 1,0,1,1)
        step(1 + 0 * 5 + 1 * 25 + 1 * 125, 4, 1);
        chk("R2", "ins gap", 32'(ins_o), 32'h1);
        // R6: full queue, bypass slots still accepted (2,3,4,1)
        step(2 + 3 * 5 + 4 * 25 + 1 * 125, 0, 1);
        chk("R6", "tail full", 32'(tail_o), 32'h7);
        chk("R5", "halt at slot 3", 32'(halt_o), 1);
        // R7: two free entries, four ordinary slots
        step(1 + 1 * 5 + 1 * 25 + 1 * 125, 2, 1);
        chk("R7", "ins two free", 32'(ins_o), 32'h3);

        // Exhaustive sweep: all slot mixes, free counts and gate inputs
        for (int g = 0; g < 8; g++)
            for (int fr = 0; fr <= DEPTH; fr++)
                for (int v = 0; v < 625; v++)
                    step(v, fr, g);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule